// File: doc/BRIEF.md
# Quad Transceiver Reset and Readiness Sequencer

This block produces the reset and ready signals for a four-channel serial transceiver quad. It merges three reset causes. The first is a power-good input, which resets the whole block asynchronously and is released in step with the clock. The second is an active-low hardware reset pin, sampled on the microprocessor clock and accepted only when it is seen low on two consecutive samples. The third is a set of software reset bits that the microprocessor writes into a small register bank.

A hardware or power reset clears everything: every channel core, the timers, and the register bank. A software reset is narrower. A bit in a channel's configuration register resets only that channel's core. A bit in a quad-wide register resets all four cores. In both cases the register contents survive.

Each channel has a ready flag. It rises a fixed number of clock cycles, `DELAY_CYC`, after the channel's last reset cause is removed. That delay stands for a 3 ms settle time, for example 300000 cycles at 100 MHz. Register reads and writes have no effect until a configuration-done input is high.

Top module: `serdes_rst_seq`

## Requirements
- R1: While `pwr_ok` is low, `core_rst` is all ones, `reg_rst` is 1, `chan_ready` is all zeros and `rd_data` is 0.
- R2: After `pwr_ok` rises, `chan_ready` becomes all ones after rising edge DELAY_CYC+2. Edges are numbered 1, 2, … from the first rising edge after the rise. After edge DELAY_CYC+1 it is still all zeros.
- R3: When `hw_rst_n` is low on only one rising edge, it is ignored. `reg_rst` stays 0, every ready flag stays 1 and the register contents are kept.
- R4: When `hw_rst_n` is low on two or more consecutive rising edges, the following happens. `reg_rst` pulses high. `core_rst` goes to all ones while `reg_rst` is high. All ready flags drop. Every register reads back 0 afterwards.
- R5: After an accepted hardware reset, `chan_ready` becomes all ones after rising edge DELAY_CYC+3. Here edge 1 is the first rising edge that samples `hw_rst_n` high again. After edge DELAY_CYC+2 it is still all zeros.
- R6: Channel i (0 to 3) has its configuration register at address i. Bit 2 of that register is the channel's software reset. While the bit is 1, `core_rst[i]` is 1 from the edge after the write, and `chan_ready[i]` is 0. The other channels stay ready.
- R7: The quad-wide register is at address 4. Its bit 0 is the quad software reset. While it is 1, all four `core_rst` bits are 1 and all ready flags are 0.
- R8: When the last software reset bit affecting a channel is cleared by a write at rising edge E, the channel's ready flag is 0 after edge E+DELAY_CYC-1 and 1 after edge E+DELAY_CYC.
- R9: A software reset leaves `reg_rst` at 0 and changes no register value; all registers read back as written.
- R10: While `cfg_done` is low, writes are ignored and `rd_data` is 0.
- R11: With `cfg_done` high, `rd_data` shows the 8-bit register at `rd_addr` one clock edge later. Addresses 5 to 7 read 0.
- R12: A channel under both its own and the quad software reset stays in reset until both bits are cleared. Its delay counts from the later clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microprocessor clock |
| pwr_ok | input | 1 | Power-good indication; low resets everything asynchronously |
| hw_rst_n | input | 1 | Active-low hardware reset pin, asynchronous |
| cfg_done | input | 1 | Configuration complete; enables register access |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| reg_rst | output | 1 | Reset for processor-visible registers |
| core_rst | output | 4 | Per-channel transceiver core reset |
| chan_ready | output | 4 | Per-channel ready flag |

## Verification
The bench checks the delay at the exact edge on both sides for each release path: power, hardware pin and software bit. An off-by-one counter, or a timer that counts from assertion, shows up as an early or late flag. A single-sample pin glitch must not clear the register bank, which a filter without qualification would do. A software reset must keep the stored values, which a design that tied the bank to the core reset would lose. The bench also tests a channel held by both its own bit and the quad bit, where a design that releases on the first clear raises ready too early. Finally, writes made before configuration is done must not set a reset bit.

// File: rtl/serdes_rst_pkg.sv
package serdes_rst_pkg;
    localparam int unsigned RSQ_CHANNELS  = 4;
    localparam int unsigned RSQ_DELAY     = 300000;
    localparam int unsigned RSQ_DATA_W    = 8;
    localparam int unsigned RSQ_ADDR_W    = 3;
    localparam int unsigned RSQ_QUAD_ADDR = 4;
    localparam int unsigned RSQ_CH_BIT    = 2;
    localparam int unsigned RSQ_QUAD_BIT  = 0;

    function automatic int unsigned cnt_w(input int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/rsq_por_sync.sv
module rsq_por_sync (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } por_st_t;

    por_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = 1'b1;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rst_n_o = st_q.s2;
endmodule

// File: rtl/rsq_hw_qual.sv
module rsq_hw_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_sync,
    output logic hw_hold
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic hold;
    } hq_st_t;

    hq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_n;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        // accept only two consecutive low samples
        st_d.hold = ~st_q.s2 & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1, hold: 1'b0};
        else        st_q <= st_d;
    end

    assign pin_sync = st_q.s2;
    assign hw_hold  = st_q.hold;
endmodule

// File: rtl/rsq_regbank.sv
module rsq_regbank #(
    parameter int unsigned N_CH      = 4,
    parameter int unsigned DW        = 8,
    parameter int unsigned AW        = 3,
    parameter int unsigned QUAD_ADDR = 4,
    parameter int unsigned CH_BIT    = 2,
    parameter int unsigned QUAD_BIT  = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            cfg_done,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic [N_CH-1:0] ch_srst,
    output logic            quad_srst
);
    typedef struct packed {
        logic [N_CH-1:0][DW-1:0] cfg;
        logic [DW-1:0]           quad;
        logic [DW-1:0]           rd;
    } rb_st_t;

    rb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_done && wr_en) begin
            for (int i = 0; i < N_CH; i++) begin
                if (wr_addr == AW'(i)) st_d.cfg[i] = wr_data;
            end
            if (wr_addr == AW'(QUAD_ADDR)) st_d.quad = wr_data;
        end
        st_d.rd = '0;
        if (cfg_done) begin
            for (int i = 0; i < N_CH; i++) begin
                if (rd_addr == AW'(i)) st_d.rd = st_q.cfg[i];
            end
            if (rd_addr == AW'(QUAD_ADDR)) st_d.rd = st_q.quad;
        end
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_bit
            assign ch_srst[g] = st_q.cfg[g][CH_BIT];
        end
    endgenerate

    assign quad_srst = st_q.quad[QUAD_BIT];
    assign rd_data   = st_q.rd;
endmodule

// File: rtl/rsq_ready_timer.sv
module rsq_ready_timer
    import serdes_rst_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 300000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic core_rst,
    output logic ready
);
    localparam int unsigned CW = cnt_w(DELAY_CYC);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rst;
        logic          rdy;
    } tm_st_t;

    tm_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rst = hold;
        if (hold)                st_d.cnt = '0;
        else if (st_q.cnt != LIMIT) st_d.cnt = st_q.cnt + CW'(1);
        st_d.rdy = !hold && (st_d.cnt == LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, rst: 1'b1, rdy: 1'b0};
        else        st_q <= st_d;
    end

    assign core_rst = st_q.rst;
    assign ready    = st_q.rdy;
endmodule

// File: rtl/serdes_rst_seq.sv
module serdes_rst_seq
    import serdes_rst_pkg::*;
#(
    parameter int unsigned N_CH      = RSQ_CHANNELS,
    parameter int unsigned DELAY_CYC = RSQ_DELAY,
    parameter int unsigned DW        = RSQ_DATA_W,
    parameter int unsigned AW        = RSQ_ADDR_W,
    parameter int unsigned QUAD_ADDR = RSQ_QUAD_ADDR,
    parameter int unsigned CH_BIT    = RSQ_CH_BIT,
    parameter int unsigned QUAD_BIT  = RSQ_QUAD_BIT
) (
    input  logic            clk,
    input  logic            pwr_ok,
    input  logic            hw_rst_n,
    input  logic            cfg_done,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            reg_rst,
    output logic [N_CH-1:0] core_rst,
    output logic [N_CH-1:0] chan_ready
);
    typedef struct packed {
        logic reg_rst;
    } top_st_t;

    logic            rst_n_int;
    logic            hw_sync;
    logic            hw_hold;
    logic [N_CH-1:0] ch_srst;
    logic            quad_srst;
    top_st_t         st_d, st_q;

    rsq_por_sync u_por (
        .clk     (clk),
        .arst_n  (pwr_ok),
        .rst_n_o (rst_n_int)
    );

    rsq_hw_qual u_hw (
        .clk      (clk),
        .rst_n    (rst_n_int),
        .pin_n    (hw_rst_n),
        .pin_sync (hw_sync),
        .hw_hold  (hw_hold)
    );

    rsq_regbank #(
        .N_CH(N_CH), .DW(DW), .AW(AW), .QUAD_ADDR(QUAD_ADDR),
        .CH_BIT(CH_BIT), .QUAD_BIT(QUAD_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n_int),
        .clr       (hw_hold),
        .cfg_done  (cfg_done),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ch_srst   (ch_srst),
        .quad_srst (quad_srst)
    );

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            rsq_ready_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
                .clk      (clk),
                .rst_n    (rst_n_int),
                .hold     (hw_hold | ch_srst[g] | quad_srst),
                .core_rst (core_rst[g]),
                .ready    (chan_ready[g])
            );
        end
    endgenerate

    always_comb begin
        st_d         = st_q;
        st_d.reg_rst = hw_hold;
    end

    always_ff @(posedge clk or negedge rst_n_int) begin
        if (!rst_n_int) st_q <= '{reg_rst: 1'b1};
        else            st_q <= st_d;
    end

    assign reg_rst = st_q.reg_rst;
endmodule

// File: rtl/serdes_rst_seq_chk.sv
module serdes_rst_seq_chk
    import serdes_rst_pkg::*;
#(
    parameter int unsigned N_CH      = 4,
    parameter int unsigned DW        = 8,
    parameter int unsigned DELAY_CYC = 300000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hw_sync,
    input logic            cfg_done,
    input logic [DW-1:0]   rd_data,
    input logic            reg_rst,
    input logic [N_CH-1:0] core_rst,
    input logic [N_CH-1:0] chan_ready
);
    localparam int unsigned CW = cnt_w(DELAY_CYC);

    logic [N_CH-1:0][CW-1:0] quiet_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) quiet_q <= '0;
        else begin
            for (int i = 0; i < N_CH; i++) begin
                if (core_rst[i])                      quiet_q[i] <= '0;
                else if (quiet_q[i] != CW'(DELAY_CYC)) quiet_q[i] <= quiet_q[i] + CW'(1);
            end
        end
    end

    p_ready_vs_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_ready & core_rst) == '0);

    p_hw_all_cores_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rst |-> (core_rst == '1));

    p_blocked_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> (rd_data == '0));

    p_two_low_samples_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rst) |-> (!$past(hw_sync, 2) && !$past(hw_sync, 3)));

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_chk
            p_delay_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(chan_ready[g]) |-> (quiet_q[g] == CW'(DELAY_CYC - 1)));
        end
    endgenerate
endmodule

bind serdes_rst_seq serdes_rst_seq_chk #(
    .N_CH(N_CH), .DW(DW), .DELAY_CYC(DELAY_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .hw_sync    (hw_sync),
    .cfg_done   (cfg_done),
    .rd_data    (rd_data),
    .reg_rst    (reg_rst),
    .core_rst   (core_rst),
    .chan_ready (chan_ready)
);

// File: tb/tb_serdes_rst_seq.sv
module tb_serdes_rst_seq;
    localparam int D = 20;

    logic       clk = 1'b0;
    logic       pwr_ok = 1'b0;
    logic       hw_rst_n = 1'b1;
    logic       cfg_done = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       reg_rst;
    logic [3:0] core_rst;
    logic [3:0] chan_ready;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] val [4] = '{8'h81, 8'h90, 8'hA3, 8'h18};

    always #2.5 clk = ~clk;

    serdes_rst_seq #(.DELAY_CYC(D)) dut (
        .clk(clk), .pwr_ok(pwr_ok), .hw_rst_n(hw_rst_n), .cfg_done(cfg_done),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .reg_rst(reg_rst), .core_rst(core_rst),
        .chan_ready(chan_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic t_power;
        edges(3);
        chk("R1 core_rst", core_rst, 4'hF);
        chk("R1 reg_rst", reg_rst, 1);
        chk("R1 ready", chan_ready, 0);
        chk("R1 rd_data", rd_data, 0);
        pwr_ok = 1'b1;
        edges(D + 1);
        chk("R2 ready before delay", chan_ready, 0);
        edges(1);
        chk("R2 ready after delay", chan_ready, 4'hF);
        chk("R2 reg_rst released", reg_rst, 0);
    endtask

    task automatic t_readwrite;
        logic [7:0] d;
        cfg_done = 1'b1;
        for (int i = 0; i < 4; i++) wr(3'(i), val[i]);
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), d);
            chk("R11 readback", d, val[i]);
        end
        rd(3'd6, d);
        chk("R11 unused address", d, 0);
        chk("R11 no core reset", core_rst, 0);
    endtask

    task automatic t_blocked;
        logic [7:0] d;
        cfg_done = 1'b0;
        wr(3'd0, 8'hFF);
        rd(3'd0, d);
        chk("R10 read blocked", d, 0);
        edges(2);
        chk("R10 write ignored core_rst", core_rst, 0);
        cfg_done = 1'b1;
        rd(3'd0, d);
        chk("R10 register unchanged", d, val[0]);
    endtask

    task automatic t_hw_short;
        logic [7:0] d;
        bit seen = 0;
        @(negedge clk);
        hw_rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        hw_rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            edges(1);
            if (reg_rst || chan_ready != 4'hF) seen = 1;
        end
        chk("R3 glitch ignored", seen, 0);
        rd(3'd3, d);
        chk("R3 registers kept", d, val[3]);
    endtask

    task automatic t_soft;
        logic [7:0] d;
        wr(3'd2, val[2] | 8'h04);
        edges(1);
        chk("R6 single channel reset", core_rst, 4'b0100);
        chk("R6 other channels ready", chan_ready, 4'b1011);
        chk("R9 reg_rst low", reg_rst, 0);
        rd(3'd2, d);
        chk("R9 value kept", d, val[2] | 8'h04);
        wr(3'd2, val[2]);
        edges(D - 1);
        chk("R8 channel not ready early", chan_ready[2], 0);
        edges(1);
        chk("R8 channel ready on time", chan_ready[2], 1);
    endtask

    task automatic t_quad;
        logic [7:0] d;
        wr(3'd4, 8'h01);
        edges(1);
        chk("R7 all cores reset", core_rst, 4'hF);
        chk("R7 none ready", chan_ready, 0);
        rd(3'd1, d);
        chk("R9 channel register kept", d, val[1]);
        wr(3'd4, 8'h00);
        edges(D - 1);
        chk("R8 quad not ready early", chan_ready, 0);
        edges(1);
        chk("R8 quad ready on time", chan_ready, 4'hF);
    endtask

    task automatic t_overlap;
        wr(3'd1, val[1] | 8'h04);
        wr(3'd4, 8'h01);
        wr(3'd4, 8'h00);
        edges(D);
        chk("R12 others ready", chan_ready, 4'b1101);
        chk("R12 channel still held", core_rst[1], 1);
        wr(3'd1, val[1]);
        edges(D - 1);
        chk("R12 not ready early", chan_ready[1], 0);
        edges(1);
        chk("R12 ready from later clear", chan_ready[1], 1);
    endtask

    task automatic t_hw_long;
        logic [7:0] d;
        bit saw_reg = 0;
        bit saw_all = 0;
        @(negedge clk);
        hw_rst_n = 1'b0;
        edges(3);
        hw_rst_n = 1'b1;
        for (int k = 1; k <= D + 3; k++) begin
            edges(1);
            if (reg_rst) saw_reg = 1;
            if (reg_rst && core_rst == 4'hF && chan_ready == 0) saw_all = 1;
            if (k == D + 2) chk("R5 not ready early", chan_ready, 0);
            if (k == D + 3) chk("R5 ready on time", chan_ready, 4'hF);
        end
        chk("R4 reg_rst pulsed", saw_reg, 1);
        chk("R4 all cores reset", saw_all, 1);
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), d);
            chk("R4 register cleared", d, 0);
        end
    endtask

    initial begin
        t_power();
        t_readwrite();
        t_blocked();
        t_hw_short();
        t_soft();
        t_quad();
        t_overlap();
        t_hw_long();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule